// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single read or write requests from a processor into timed strobes on an external memory bus. Each request goes through three steps. First comes an address step, while the address latch enable (ALE) is high. Next comes a command step, while the active-low read or write strobe is asserted. Last comes an optional idle step, during which external drivers can turn off before the next address appears. The sequencer runs on a clock at twice the processor rate, so every step boundary falls on a half-processor-clock tick. Two ticks make one processor clock.

Three configuration inputs are sampled together with each request. The first selects a multiplexed bus, where the address and the data share one bus, or a demultiplexed bus. The second turns off the programmable turn-off gap. The gap is present when this input is 0. The third delays the command edge by half a processor clock without making the cycle any longer. In multiplexed mode one extra gap of one processor clock is always added. The requester is not stalled during a gap: a request can be accepted then, and it is held until the gap has ended.

Top module: `ebs_seq`

## Requirements
- R1: During reset and right after it, `ale` is 0, `rd_n` and `wr_n` are 1, `bus_oe` is 0 and `req_ready` is 1.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. In the next two ticks `ale` is 1, and `addr_out` carries the request address from then until the next request's address step.
- R3: With `cfg_cmd_dly` = 0, the selected strobe falls in the same tick that `ale` falls, and it stays low for four ticks.
- R4: With `cfg_cmd_dly` = 1, the strobe falls one tick after `ale` falls and rises in the same tick as it would without the delay, so it is low for three ticks and the cycle length does not change.
- R5: With `cfg_tri_skip` = 0, a gap of two ticks follows the strobe's rising tick. During the gap `ale`, `bus_oe` and both strobes are inactive, and `addr_out` keeps the old address.
- R6: With `cfg_mux` = 1, two more gap ticks are always added. The gap is therefore 0 or 2 ticks demultiplexed and 2 or 4 ticks multiplexed.
- R7: `req_ready` is 0 from the acceptance edge until the strobe's rising tick. It is 1 during a gap until a request is accepted there. A request that waits for ready starts its address step right after the gap, or one tick after the strobe rises when there is no gap.
- R8: Multiplexed mode drives `bus_out` with the low address bits while `ale` is 1. Writes, in both modes, drive `bus_out` with the write data for all four command ticks. `bus_oe` is 1 exactly in these ticks, so it is 0 throughout a read command.
- R9: A read captures `bus_in` on its last command tick. `rd_valid` is 1 for the tick in which `rd_n` rises, and `rd_data` then holds the captured value.
- R10: `rd_n` is asserted only for reads and `wr_n` only for writes, never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the processor rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| cfg_mux | input | 1 | 1 = multiplexed address/data bus |
| cfg_tri_skip | input | 1 | 1 = omit the programmable turn-off gap |
| cfg_cmd_dly | input | 1 | 1 = delay command edge by one tick |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_oe | output | 1 | Output enable for the data/address bus |
| bus_out | output | DW | Bus output value |
| bus_in | input | DW | Bus input value |
| addr_out | output | AW | Demultiplexed address bus |
| rd_data | output | DW | Captured read data |
| rd_valid | output | 1 | Read data valid pulse |

## Verification
All pin outputs are decoded from registered state without further delay. Counted from the acceptance edge, ALE therefore covers tick offsets 0 and 1 and the command covers offsets 2 to 5, or 3 to 5 with the delay. The strobe rises at offset 6, and the next request's ALE is due at offset 6 plus the gap, or at offset 7 when there is no gap. Read data and its valid pulse are registered once and are due at offset 6. The bench drives its inputs and samples the outputs at falling edges, keeps its own tick offset from the acceptance edge, and compares every output against these arithmetic windows at every tick of a two-request sequence, for all sixteen settings of mode, gap, delay and direction.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_GAP
  } phase_e;

  // Turn-off gap in ticks: programmable part plus implicit multiplexed part.
  function automatic int gap_ticks(logic mux, logic tri_skip, int unit);
    return (tri_skip ? 0 : unit) + (mux ? unit : 0);
  endfunction

  // Command strobe active at index idx of the command phase.
  function automatic logic cmd_on(logic dly, int idx);
    return !dly || (idx >= 1);
  endfunction

endpackage

// File: rtl/ebs_req_latch.sv
module ebs_req_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc,
  input  logic         start,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] act_q
);

  logic [W-1:0] pend_q;

  // Holding copy: loaded on every acceptance.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (acc) begin
      pend_q <= d_in;
    end
  end

  // Active copy: only changes when an address step begins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (start) begin
      act_q <= acc ? d_in : pend_q;
    end
  end

endmodule

// File: rtl/ebs_phase_fsm.sv
module ebs_phase_fsm
  import ebs_pkg::*;
#(
  parameter int ADDR_T = 2,
  parameter int CMD_T  = 4,
  parameter int UNIT   = 2,
  parameter int CW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          cur_mux,
  input  logic          cur_tri_skip,
  output phase_e        phase,
  output logic [CW-1:0] cnt,
  output logic          ready,
  output logic          acc,
  output logic          start,
  output logic          in_gap
);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q;
  logic [CW-1:0] gap_len;
  logic          addr_end, cmd_end, gap_end;

  assign gap_len  = CW'(gap_ticks(cur_mux, cur_tri_skip, UNIT));
  assign ready    = (ph_q == PH_IDLE) || ((ph_q == PH_GAP) && !pend_q);
  assign acc      = req_valid && ready;
  assign addr_end = (ph_q == PH_ADDR) && (cnt_q == CW'(ADDR_T - 1));
  assign cmd_end  = (ph_q == PH_CMD) && (cnt_q == CW'(CMD_T - 1));
  assign gap_end  = (ph_q == PH_GAP) && (cnt_q == '0);
  assign start    = ((ph_q == PH_IDLE) && acc) || (gap_end && (pend_q || acc));
  assign in_gap   = (ph_q == PH_GAP);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    case (ph_q)
      PH_IDLE: begin
        if (acc) begin
          ph_d  = PH_ADDR;
          cnt_d = '0;
        end
      end
      PH_ADDR: begin
        if (addr_end) begin
          ph_d  = PH_CMD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_CMD: begin
        if (cmd_end) begin
          if (gap_len == '0) begin
            ph_d  = PH_IDLE;
            cnt_d = '0;
          end else begin
            ph_d  = PH_GAP;
            cnt_d = gap_len - 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_GAP: begin
        if (gap_end) begin
          ph_d  = start ? PH_ADDR : PH_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (start) begin
        pend_q <= 1'b0;
      end else if (acc && (ph_q == PH_GAP)) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign phase = ph_q;
  assign cnt   = cnt_q;

endmodule

// File: rtl/ebs_pin_drive.sv
module ebs_pin_drive
  import ebs_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CW    = 3,
  parameter int CMD_T = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic [CW-1:0] cnt,
  input  logic          act_mux,
  input  logic          act_dly,
  input  logic          act_write,
  input  logic [AW-1:0] act_addr,
  input  logic [DW-1:0] act_wdata,
  input  logic [DW-1:0] bus_in,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          bus_oe,
  output logic [DW-1:0] bus_out,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  logic [DW-1:0] addr_lo;
  logic          addr_ph, cmd_ph, cmd_act, cmd_last, drive_addr, drive_data;

  generate
    if (AW >= DW) begin : g_addr_trunc
      assign addr_lo = act_addr[DW-1:0];
    end else begin : g_addr_ext
      assign addr_lo = {{(DW - AW){1'b0}}, act_addr};
    end
  endgenerate

  assign addr_ph    = (phase == PH_ADDR);
  assign cmd_ph     = (phase == PH_CMD);
  assign cmd_act    = cmd_ph && cmd_on(act_dly, 32'(cnt));
  assign cmd_last   = cmd_ph && (cnt == CW'(CMD_T - 1));
  assign drive_addr = addr_ph && act_mux;
  assign drive_data = cmd_ph && act_write;

  assign ale      = addr_ph;
  assign rd_n     = !(cmd_act && !act_write);
  assign wr_n     = !(cmd_act && act_write);
  assign bus_oe   = drive_addr || drive_data;
  assign bus_out  = drive_addr ? addr_lo : (drive_data ? act_wdata : '0);
  assign addr_out = act_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cmd_last && !act_write;
      if (cmd_last && !act_write) begin
        rd_data <= bus_in;
      end
    end
  end

endmodule

// File: rtl/ebs_seq.sv
module ebs_seq #(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int ADDR_T = 2,
  parameter int CMD_T  = 4,
  parameter int UNIT   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          cfg_mux,
  input  logic          cfg_tri_skip,
  input  logic          cfg_cmd_dly,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          bus_oe,
  output logic [DW-1:0] bus_out,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  import ebs_pkg::*;

  localparam int MAXT = (ADDR_T > CMD_T) ? ((ADDR_T > 2 * UNIT) ? ADDR_T : 2 * UNIT)
                                         : ((CMD_T > 2 * UNIT) ? CMD_T : 2 * UNIT);
  localparam int CW   = $clog2(MAXT + 1);
  localparam int W    = AW + DW + 4;

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          acc, start, in_gap;
  logic [W-1:0]  d_in, act;
  logic          act_mux, act_tri_skip, act_dly, act_write;
  logic [DW-1:0] act_wdata;
  logic [AW-1:0] act_addr;

  assign d_in = {cfg_mux, cfg_tri_skip, cfg_cmd_dly, req_write, req_wdata, req_addr};
  assign {act_mux, act_tri_skip, act_dly, act_write, act_wdata, act_addr} = act;

  ebs_req_latch #(.W(W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .acc   (acc),
    .start (start),
    .d_in  (d_in),
    .act_q (act)
  );

  ebs_phase_fsm #(.ADDR_T(ADDR_T), .CMD_T(CMD_T), .UNIT(UNIT), .CW(CW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .cur_mux      (act_mux),
    .cur_tri_skip (act_tri_skip),
    .phase        (phase),
    .cnt          (cnt),
    .ready        (req_ready),
    .acc          (acc),
    .start        (start),
    .in_gap       (in_gap)
  );

  ebs_pin_drive #(.AW(AW), .DW(DW), .CW(CW), .CMD_T(CMD_T)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .cnt       (cnt),
    .act_mux   (act_mux),
    .act_dly   (act_dly),
    .act_write (act_write),
    .act_addr  (act_addr),
    .act_wdata (act_wdata),
    .bus_in    (bus_in),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .bus_oe    (bus_oe),
    .bus_out   (bus_out),
    .addr_out  (addr_out),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: rtl/ebs_seq_chk.sv
module ebs_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic bus_oe,
  input logic req_ready,
  input logic rd_valid,
  input logic in_gap,
  input logic cur_mux,
  input logic cur_dly
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R10

  AST_ALE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n)); // R3

  AST_EDGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale) && !cur_dly) |-> (!rd_n || !wr_n)); // R3

  AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale) && cur_dly) |-> (rd_n && wr_n)); // R4

  AST_EDGE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale) && cur_dly) |=> (!rd_n || !wr_n)); // R4

  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> (!ale && rd_n && wr_n && !bus_oe)); // R5

  AST_MUX_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && cur_mux) |-> !bus_oe); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !req_ready); // R7

  AST_RDATA_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(rd_n)); // R9

endmodule

bind ebs_seq ebs_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .bus_oe    (bus_oe),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .in_gap    (in_gap),
  .cur_mux   (act_mux),
  .cur_dly   (act_dly)
);

// File: tb/test_ebs_seq.sv
module test_ebs_seq;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int TP = 4;
  localparam int NT = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr, addr_out;
  logic [DW-1:0] req_wdata, bus_out, bus_in, rd_data;
  logic          cfg_mux, cfg_tri_skip, cfg_cmd_dly;
  logic          ale, rd_n, wr_n, bus_oe, rd_valid;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(TP / 2) clk = ~clk;

  ebs_seq #(.AW(AW), .DW(DW)) i_ebs_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .cfg_mux      (cfg_mux),
    .cfg_tri_skip (cfg_tri_skip),
    .cfg_cmd_dly  (cfg_cmd_dly),
    .ale          (ale),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .bus_oe       (bus_oe),
    .bus_out      (bus_out),
    .bus_in       (bus_in),
    .addr_out     (addr_out),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid)
  );

  task automatic chk(input string tag, input int combo, input int tick,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s combo=%0d tick=%0d actual=%0h expected=%0h", tag, combo, tick, act, exp);
    end
  endtask

  initial begin
    #(TP * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic m, t, d, w;
    int g, b0, accb;
    bit drop;
    logic [AW-1:0] aA, aB;
    logic [DW-1:0] wA, wB, pA, pB;
    bit inAa, inAc, inAs, inBa, inBc, inBs, e_cmd, e_oe, e_rdv;
    logic [DW-1:0] e_bus, e_rdd;

    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    cfg_mux = 0; cfg_tri_skip = 0; cfg_cmd_dly = 0; bus_in = '0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ale", -1, 0, 32'(ale), 0);
    chk("R1 rd_n", -1, 0, 32'(rd_n), 1);
    chk("R1 wr_n", -1, 0, 32'(wr_n), 1);
    chk("R1 bus_oe", -1, 0, 32'(bus_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", -1, 0, 32'(req_ready), 1);
    chk("R1 ale after", -1, 0, 32'(ale), 0);

    for (int c = 0; c < 16; c++) begin
      m = c[0]; t = c[1]; d = c[2]; w = c[3];
      g  = (t ? 0 : 2) + (m ? 2 : 0);
      b0 = 6 + ((g > 1) ? g : 1);
      aA = 16'h1000 + 16'(c * 16'h0111);
      aB = 16'h8000 ^ 16'(c * 16'h0203);
      wA = 16'hC000 | 16'(c);
      wB = 16'h3000 | 16'(c << 4);
      pA = 16'h5A00 | 16'(c);
      pB = 16'hA500 | 16'(c << 2);
      cfg_mux = m; cfg_tri_skip = t; cfg_cmd_dly = d; req_write = w;
      req_addr = aA; req_wdata = wA; bus_in = pA; req_valid = 1'b1;
      drop = 0; accb = -1;

      for (int s = 0; s < NT; s++) begin
        @(negedge clk);
        inAa = (s < 2);
        inAs = (s >= 2) && (s < 6);
        inAc = (s >= 2 + int'(d)) && (s < 6);
        inBa = (s >= b0) && (s < b0 + 2);
        inBs = (s >= b0 + 2) && (s < b0 + 6);
        inBc = (s >= b0 + 2 + int'(d)) && (s < b0 + 6);
        e_cmd = inAc || inBc;
        e_oe  = ((inAa || inBa) && m) || ((inAs || inBs) && w);
        e_bus = inAa ? aA : (inBa ? aB : (inAs ? wA : wB));
        e_rdv = !w && ((s == 6) || (s == b0 + 6));
        e_rdd = (s == 6) ? pA : pB;

        chk((s < 6) ? "R2 ale" : "R5/R6 ale", c, s, 32'(ale), 32'(inAa || inBa));
        chk(w ? "R10 rd_n" : (d ? "R4 rd_n" : "R3 rd_n"), c, s, 32'(rd_n), 32'(!(e_cmd && !w)));
        chk(!w ? "R10 wr_n" : (d ? "R4 wr_n" : "R3 wr_n"), c, s, 32'(wr_n), 32'(!(e_cmd && w)));
        chk("R7 ready", c, s, 32'(req_ready),
            32'(!((s < 6) || ((s >= b0) && (s < b0 + 6)) || ((g > 0) && (s > 6) && (s < 6 + g)))));
        chk("R8 bus_oe", c, s, 32'(bus_oe), 32'(e_oe));
        if (e_oe) chk("R8 bus_out", c, s, 32'(bus_out), 32'(e_bus));
        chk("R2 addr_out", c, s, 32'(addr_out), 32'((s < b0) ? aA : aB));
        chk("R9 rd_valid", c, s, 32'(rd_valid), 32'(e_rdv));
        if (e_rdv) chk("R9 rd_data", c, s, 32'(rd_data), 32'(e_rdd));

        if (s == 0) begin
          req_addr = aB; req_wdata = wB;
        end else if (drop) begin
          req_valid = 1'b0; drop = 0;
        end else if (req_valid && req_ready) begin
          accb = s; drop = 1;
        end
        if (s == 7) bus_in = pB;
      end
      chk("R7 second accept tick", c, 0, 32'(accb), 32'(6));
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule